// File: doc/BRIEF.md
# DMA External Request Sampling Controller

This block sits between an active-low external transfer-request pin and a DMA channel sequencer. On each rising bus clock it may sample the request. It recognises a request either by level (the pin is low at a sample point) or by edge (the pin was high in the previous clock and is low at the sample point). Once it has recognised a request, it waits a fixed start latency and then raises a one-cycle transfer-start request. The request acknowledge output pulses in the same cycle.

After a request has been recognised, the sampler closes. It reopens at a point that depends on two settings: the detection type, and whether the channel moves data in one bus cycle (single-address) or in a read cycle followed by a write cycle (dual-address). The sequencer reports its progress through four one-cycle strobes: read start, read end, write start and single-cycle start. The same timing applies to cycle-steal and burst operation, so the block has no mode input for that choice.

The transfer acknowledge output marks the bus cycle that belongs to each granted transfer. In single-address operation that is the single transfer cycle. In dual-address operation a configuration bit selects either the read cycle or the write cycle.

Top module: `dreq_smp_ctrl`

## Requirements
- R1: While `rst_n` is low, `xfer_req`, `drak` and `dack` are low. After reset the sampler is open, so a request present in the first clock after release is recognised.
- R2: With `cfg_edge`=0, a low `dreq_n` at an open sample in cycle S raises `xfer_req` in cycle S+4 only.
- R3: With `cfg_edge`=1, `dreq_n` high in cycle S-1 and low at an open sample in cycle S raises `xfer_req` in cycle S+5 only. A request held low produces no further start.
- R4: From the cycle after a recognised sample until the reopen point, `dreq_n` is not sampled, and a request pulse in that window produces no start.
- R5: With `cfg_single`=0 and `cfg_edge`=0, sampling reopens in the cycle after `bus_wr_start`.
- R6: With `cfg_single`=0 and `cfg_edge`=1, sampling reopens in the same cycle as `bus_rd_end`.
- R7: With `cfg_single`=1 and `cfg_edge`=0, sampling reopens in the cycle after `bus_cyc_start`.
- R8: With `cfg_single`=1 and `cfg_edge`=1, sampling reopens in the cycle after `drak`, whatever the bus strobes do.
- R9: Once reopened, the sampler samples on every clock until it recognises a request. With level detection and the request held low, the next start comes exactly 4 cycles after the reopen cycle.
- R10: With `cfg_single`=1, `dack` is high in the cycle of the first `bus_cyc_start` after a start, and `cfg_ack_wr` has no effect.
- R11: With `cfg_single`=0, `dack` is high in the cycle of the first `bus_rd_start` after a start when `cfg_ack_wr`=0, and of the first `bus_wr_start` when `cfg_ack_wr`=1.
- R12: Bus strobes that arrive while no transfer is owed do not raise `dack`. Strobes that arrive before the sampler has issued its start do not reopen the sampler.
- R13: `drak` is high exactly in the cycles where `xfer_req` is high, and each pulse lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all sampling on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_edge | input | 1 | 1 = edge detection, 0 = level detection |
| cfg_single | input | 1 | 1 = single-address transfers, 0 = dual-address |
| cfg_ack_wr | input | 1 | Dual-address only: 1 = acknowledge in write cycle, 0 = in read cycle |
| dreq_n | input | 1 | External transfer request, active low |
| bus_rd_start | input | 1 | One-cycle strobe: transfer read cycle begins |
| bus_rd_end | input | 1 | One-cycle strobe: transfer read cycle ends |
| bus_wr_start | input | 1 | One-cycle strobe: transfer write cycle begins |
| bus_cyc_start | input | 1 | One-cycle strobe: single-address transfer cycle begins |
| xfer_req | output | 1 | One-cycle request to the sequencer to start a transfer |
| drak | output | 1 | Request acknowledge pulse |
| dack | output | 1 | Transfer acknowledge for the selected bus cycle |

## Verification
Several properties are checked on every cycle, in any mode: outputs stay quiet during reset, `drak` accompanies each one-cycle start, two starts are never closer than the minimum start latency allows, and `dack` never appears without an outstanding start. Other behaviour can only be shown by the bench's scenarios. These are the exact cycle of each start, the reopen point of each of the four detection and address combinations, the missed pulses just before that point, and the cycle chosen for `dack`. The bench sweeps every configuration against request pulses placed at each offset around the reopen point, and also against a request held low.

// File: rtl/dreq_smp_pkg.sv
package dreq_smp_pkg;

  typedef enum logic [1:0] {
    ST_OPEN  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_ISSUE = 2'd2,
    ST_BUSY  = 2'd3
  } smp_state_t;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned min_u(input int unsigned a, input int unsigned b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/dreq_smp_detect.sv
module dreq_smp_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_mode,
  input  logic smp_open,
  input  logic dreq_n,
  output logic hit
);

  logic prev_q;
  logic prev_d;
  logic lvl_seen;
  logic edg_seen;

  // The previous pin value is captured every clock, so a falling edge is
  // defined between two consecutive clocks even after the sampler reopens.
  always_comb begin
    prev_d   = dreq_n;
    lvl_seen = ~dreq_n;
    edg_seen = prev_q & ~dreq_n;
    hit      = smp_open & (edge_mode ? edg_seen : lvl_seen);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
    end else begin
      prev_q <= prev_d;
    end
  end

endmodule

// File: rtl/dreq_smp_seq.sv
module dreq_smp_seq
  import dreq_smp_pkg::*;
#(
  parameter int unsigned LAT_LEVEL = 4,
  parameter int unsigned LAT_EDGE  = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_mode,
  input  logic single_mode,
  input  logic hit,
  input  logic rd_end,
  input  logic wr_start,
  input  logic cyc_start,
  output logic smp_open,
  output logic issue,
  output logic drak
);

  localparam int unsigned LAT_MAX = max_u(LAT_LEVEL, LAT_EDGE);
  localparam int unsigned CNT_W   = $clog2(LAT_MAX) + 1;
  localparam logic [CNT_W-1:0] LIM_LVL = CNT_W'(LAT_LEVEL - 2);
  localparam logic [CNT_W-1:0] LIM_EDG = CNT_W'(LAT_EDGE - 2);

  smp_state_t       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             drak_q, drak_d;
  logic [CNT_W-1:0] lim;
  logic             reopen_now;
  logic             reopen_next;
  logic             start_wait;

  // Reopen rules, by address mode and detection type.
  always_comb begin
    reopen_now  = 1'b0;
    reopen_next = 1'b0;
    if (state_q == ST_BUSY) begin
      if (!single_mode) begin
        if (edge_mode) reopen_now  = rd_end;
        else           reopen_next = wr_start;
      end else if (!edge_mode) begin
        reopen_next = cyc_start;
      end
    end
  end

  always_comb begin
    lim        = edge_mode ? LIM_EDG : LIM_LVL;
    smp_open   = (state_q == ST_OPEN) | reopen_now;
    start_wait = smp_open & hit;
    state_d    = state_q;
    case (state_q)
      ST_OPEN: begin
        if (start_wait) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (cnt_q == lim) state_d = ST_ISSUE;
      end
      ST_ISSUE: begin
        state_d = (single_mode && edge_mode) ? ST_OPEN : ST_BUSY;
      end
      ST_BUSY: begin
        if (start_wait)                    state_d = ST_WAIT;
        else if (reopen_now || reopen_next) state_d = ST_OPEN;
      end
      default: state_d = ST_OPEN;
    endcase
  end

  always_comb begin
    cnt_en = start_wait | (state_q == ST_WAIT);
    cnt_d  = start_wait ? '0 : cnt_q + 1'b1;
    drak_d = (state_d == ST_ISSUE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OPEN;
      cnt_q   <= '0;
      drak_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      drak_q  <= drak_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign issue = (state_q == ST_ISSUE);
  assign drak  = drak_q;

endmodule

// File: rtl/dreq_smp_ack.sv
module dreq_smp_ack (
  input  logic clk,
  input  logic rst_n,
  input  logic single_mode,
  input  logic ack_wr,
  input  logic issue,
  input  logic rd_start,
  input  logic wr_start,
  input  logic cyc_start,
  output logic dack
);

  logic owed_q, owed_d;
  logic sel_stb;

  always_comb begin
    if (single_mode) sel_stb = cyc_start;
    else             sel_stb = ack_wr ? wr_start : rd_start;
    dack   = owed_q & sel_stb;
    owed_d = issue | (owed_q & ~sel_stb);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owed_q <= 1'b0;
    end else begin
      owed_q <= owed_d;
    end
  end

endmodule

// File: rtl/dreq_smp_ctrl.sv
module dreq_smp_ctrl #(
  parameter int unsigned LAT_LEVEL = 4,
  parameter int unsigned LAT_EDGE  = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_edge,
  input  logic cfg_single,
  input  logic cfg_ack_wr,
  input  logic dreq_n,
  input  logic bus_rd_start,
  input  logic bus_rd_end,
  input  logic bus_wr_start,
  input  logic bus_cyc_start,
  output logic xfer_req,
  output logic drak,
  output logic dack
);

  logic smp_open;
  logic hit;
  logic issue;

  dreq_smp_detect detect_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .edge_mode (cfg_edge),
    .smp_open  (smp_open),
    .dreq_n    (dreq_n),
    .hit       (hit)
  );

  dreq_smp_seq #(
    .LAT_LEVEL (LAT_LEVEL),
    .LAT_EDGE  (LAT_EDGE)
  ) seq_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .edge_mode   (cfg_edge),
    .single_mode (cfg_single),
    .hit         (hit),
    .rd_end      (bus_rd_end),
    .wr_start    (bus_wr_start),
    .cyc_start   (bus_cyc_start),
    .smp_open    (smp_open),
    .issue       (issue),
    .drak        (drak)
  );

  dreq_smp_ack ack_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .single_mode (cfg_single),
    .ack_wr      (cfg_ack_wr),
    .issue       (issue),
    .rd_start    (bus_rd_start),
    .wr_start    (bus_wr_start),
    .cyc_start   (bus_cyc_start),
    .dack        (dack)
  );

  assign xfer_req = issue;

endmodule

// File: rtl/dreq_smp_chk.sv
module dreq_smp_chk
  import dreq_smp_pkg::*;
#(
  parameter int unsigned LAT_LEVEL = 4,
  parameter int unsigned LAT_EDGE  = 5
) (
  input logic clk,
  input logic rst_n,
  input logic xfer_req,
  input logic drak,
  input logic dack
);

  localparam int unsigned LMIN  = min_u(LAT_LEVEL, LAT_EDGE);
  localparam int unsigned GAP_W = $clog2(max_u(LAT_LEVEL, LAT_EDGE) + 2) + 1;
  localparam logic [GAP_W-1:0] GAP_FIRST = GAP_W'(LMIN);
  localparam logic [GAP_W-1:0] GAP_NEXT  = GAP_W'(LMIN + 1);

  logic [GAP_W-1:0] gap_q;
  logic             seen_q;
  logic [3:0]       out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
      out_q  <= '0;
    end else begin
      if (xfer_req)        gap_q <= GAP_W'(1);
      else if (~&gap_q)    gap_q <= gap_q + 1'b1;
      if (xfer_req)        seen_q <= 1'b1;
      if (xfer_req && !dack && ~&out_q)     out_q <= out_q + 1'b1;
      else if (dack && !xfer_req && out_q != 0) out_q <= out_q - 1'b1;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> (!xfer_req && !drak && !dack)) else $error("reset quiet"); // R1
  AST_FIRST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) (xfer_req && !seen_q) |-> (gap_q >= GAP_FIRST)) else $error("first latency"); // R2
  AST_NEXT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) (xfer_req && seen_q) |-> (gap_q >= GAP_NEXT)) else $error("next latency"); // R4
  AST_DRAK_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n) xfer_req |-> drak) else $error("drak missing"); // R13
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) xfer_req |=> !xfer_req) else $error("start too long"); // R13
  AST_DACK_OWED: assert property (@(posedge clk) disable iff (!rst_n) dack |-> (out_q != 0)) else $error("dack not owed"); // R12

endmodule

bind dreq_smp_ctrl dreq_smp_chk #(
  .LAT_LEVEL (LAT_LEVEL),
  .LAT_EDGE  (LAT_EDGE)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .xfer_req (xfer_req),
  .drak     (drak),
  .dack     (dack)
);

// File: tb/dreq_smp_ctrl_tb_top.sv
`timescale 1ns/1ps
module dreq_smp_ctrl_tb_top;

  localparam int LVL_LAT = 4;
  localparam int EDG_LAT = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_edge, cfg_single, cfg_ack_wr;
  logic dreq_n;
  logic bus_rd_start, bus_rd_end, bus_wr_start, bus_cyc_start;
  logic xfer_req, drak, dack;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  dreq_smp_ctrl dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_edge      (cfg_edge),
    .cfg_single    (cfg_single),
    .cfg_ack_wr    (cfg_ack_wr),
    .dreq_n        (dreq_n),
    .bus_rd_start  (bus_rd_start),
    .bus_rd_end    (bus_rd_end),
    .bus_wr_start  (bus_wr_start),
    .bus_cyc_start (bus_cyc_start),
    .xfer_req      (xfer_req),
    .drak          (drak),
    .dack          (dack)
  );

  task automatic check(input string tag, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  function automatic int reopen_off(input logic e, input logic s);
    if (!s) return e ? 2 : 4;
    return e ? 1 : 3;
  endfunction

  function automatic string mode_tag(input logic e, input logic s);
    if (!s) return e ? "R6" : "R5";
    return e ? "R8" : "R7";
  endfunction

  // off < 0 : request held low throughout; otherwise one-cycle pulse at L+off
  task automatic trial(input logic e, input logic s, input logic aw, input int off);
    int lat, ro, x2, dk, ncyc, p;
    bit hold;
    string t;
    lat  = e ? EDG_LAT : LVL_LAT;
    ro   = reopen_off(e, s);
    hold = (off < 0);
    p    = lat + off;
    x2   = -1;
    if (hold) begin
      if (!e) x2 = lat + ro + lat;
    end else if (off >= ro) begin
      x2 = p + lat;
    end
    if (s)       dk = lat + 2;
    else if (aw) dk = lat + 3;
    else         dk = lat + 1;
    ncyc = 2 * lat + 12;

    @(negedge clk);
    rst_n = 1'b0;
    cfg_edge = e; cfg_single = s; cfg_ack_wr = aw;
    dreq_n = 1'b1;
    bus_rd_start = 0; bus_rd_end = 0; bus_wr_start = 0; bus_cyc_start = 0;
    @(negedge clk);
    #1;
    check("R1", xfer_req, 1'b0, "xfer_req in reset");
    check("R1", drak, 1'b0, "drak in reset");
    check("R1", dack, 1'b0, "dack in reset");
    for (int c = 0; c < ncyc; c++) begin
      @(negedge clk);
      if (c == 0) rst_n = 1'b1;
      dreq_n        = !((c == 0) || hold || (c == p));
      bus_rd_start  = (c == 1) || (!s && c == lat + 1);
      bus_rd_end    = (c == 1) || (!s && c == lat + 2);
      bus_wr_start  = (c == 1) || (!s && c == lat + 3);
      bus_cyc_start = (c == 1) || (s && c == lat + 2);
      #1;
      if (c <= lat)                  t = e ? "R3" : "R2";
      else if (hold)                 t = e ? "R3" : "R9";
      else if (off < ro)             t = "R4";
      else                           t = mode_tag(e, s);
      check(t, xfer_req, logic'((c == lat) || (c == x2)), $sformatf("xfer_req c=%0d e=%0b s=%0b off=%0d", c, e, s, off));
      check("R13", drak, logic'((c == lat) || (c == x2)), $sformatf("drak c=%0d", c));
      if (c == dk) check(s ? "R10" : "R11", dack, 1'b1, $sformatf("dack c=%0d aw=%0b", c, aw));
      else         check("R12", dack, 1'b0, $sformatf("dack c=%0d aw=%0b", c, aw));
    end
  endtask

  initial begin
    #3000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_edge = 0; cfg_single = 0; cfg_ack_wr = 0;
    dreq_n = 1'b1;
    bus_rd_start = 0; bus_rd_end = 0; bus_wr_start = 0; bus_cyc_start = 0;
    for (int e = 0; e < 2; e++)
      for (int s = 0; s < 2; s++)
        for (int aw = 0; aw < 2; aw++)
          for (int off = -1; off <= 6; off++)
            trial(logic'(e), logic'(s), logic'(aw), off);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule